// File: doc/BRIEF.md
# Set-Less-Than Compare Unit

This execute-stage block evaluates the four set-less-than operations of a 32-bit integer pipeline: a signed and an unsigned register-register compare, and a signed and an unsigned register-immediate compare. Each operation takes a first operand `rs`, a second operand that is either `rt` or a 16-bit immediate widened inside the block, and an operation code. The result is a full-width word holding 1 when the first operand is below the second and 0 otherwise.

Both unsigned and signed immediate forms widen the immediate by copying its sign bit. The unsigned immediate compare therefore treats codes 0x8000..0xFFFF as the highest 32768 unsigned values, not as 32768..65535.

Operands enter on a valid/ready stream and results leave on another one. An input beat is taken on a rising edge where `in_valid` and `in_ready` are both high. Its result is registered and presented with `out_valid` from the next cycle. While `out_valid` is high and `out_ready` is low, the result stays unchanged and `in_ready` is low, so back-pressure reaches the producer. When `out_ready` is high, one beat is accepted every cycle. The compare can be built from dedicated comparators or from a subtraction with borrow and overflow logic, chosen by a parameter.

Top module: `slt_unit`

## Requirements
- R1: While and directly after reset (`rst_n` low, active-low asynchronous), `out_valid` is 0 and `in_ready` is 1.
- R2: Op code 2'b00 compares `rs` and `rt` as two's-complement values; `rs`=0x80000000 against `rt`=0x7FFFFFFF gives 1.
- R3: Op code 2'b01 compares `rs` and `rt` as unsigned values; `rs`=0x80000000 against `rt`=0x7FFFFFFF gives 0.
- R4: Op code 2'b10 widens the immediate with its sign bit and compares signed; `rs`=0xFFFFFFFE against immediate 0xFFFF (-1) gives 1.
- R5: Op code 2'b11 widens the immediate with its sign bit and compares unsigned; immediate 0x8000 stands for 0xFFFF8000 and 0xFFFF for 0xFFFFFFFF, so `rs`=0x00010000 against 0x8000 gives 1.
- R6: `out_result` is always 32'h00000001 or 32'h00000000; equal operands give 0 in every mode.
- R7: The immediate forms (op bit 1 = 1) ignore `rt`, and the register forms ignore `in_imm`.
- R8: A beat accepted on a rising edge shows its result with `out_valid` = 1 from that edge until it is consumed.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_result` and `out_valid` hold.
- R10: With `out_ready` held at 1, `in_ready` stays 1 and a beat is accepted on every cycle. When no new beat arrives, `out_valid` falls after the held beat is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_op | input | 2 | Operation: 00 signed reg, 01 unsigned reg, 10 signed imm, 11 unsigned imm |
| in_rs | input | 32 | First operand |
| in_rt | input | 32 | Second operand for register forms |
| in_imm | input | 16 | Immediate for immediate forms |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_result | output | 32 | Compare result, 0 or 1 |

## Verification
Every result is due exactly one rising edge after its beat is accepted. The bench drives and samples on falling edges, so the result of the beat driven at one falling edge is read at the next one, while the following beat is already presented. A back-pressure episode shows that a held result survives several stalled cycles and that a beat presented while stalled is accepted only on the edge after `out_ready` returns.

// File: rtl/slt_pkg.sv
package slt_pkg;
  // bit 1: second operand is the immediate, bit 0: unsigned compare
  typedef enum logic [1:0] {
    SLT_OP_REG_S = 2'b00,
    SLT_OP_REG_U = 2'b01,
    SLT_OP_IMM_S = 2'b10,
    SLT_OP_IMM_U = 2'b11
  } slt_op_e;

  localparam int unsigned SLT_OP_W = 2;

  function automatic logic op_uses_imm(slt_op_e op);
    return op[1];
  endfunction

  function automatic logic op_is_unsigned(slt_op_e op);
    return op[0];
  endfunction
endpackage

// File: rtl/slt_operand_sel.sv
module slt_operand_sel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic [DATA_W-1:0] rt,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  output logic [DATA_W-1:0] opb
);
  localparam int unsigned EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_wide;

  // both immediate forms replicate the sign bit
  assign imm_wide = {{EXT_W{imm[IMM_W-1]}}, imm};

  always_comb begin
    opb = use_imm ? imm_wide : rt;
  end
endmodule

// File: rtl/slt_compare.sv
module slt_compare #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CMP_STYLE = 1   // 0: comparators, 1: subtract
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_unsigned,
  output logic              lt
);
  localparam int unsigned MSB = DATA_W - 1;

  generate
    if (CMP_STYLE == 0) begin : g_cmp
      logic lt_s, lt_u;
      always_comb begin
        lt_u = a < b;
        lt_s = $signed(a) < $signed(b);
        lt   = is_unsigned ? lt_u : lt_s;
      end
    end else begin : g_sub
      logic [DATA_W:0] diff;
      logic            borrow, ovf, neg;
      always_comb begin
        diff   = {1'b0, a} - {1'b0, b};
        borrow = diff[DATA_W];
        neg    = diff[MSB];
        ovf    = (a[MSB] ^ b[MSB]) & (neg ^ a[MSB]);
        lt     = is_unsigned ? borrow : (neg ^ ovf);
      end
    end
  endgenerate
endmodule

// File: rtl/slt_out_reg.sv
module slt_out_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              lt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result
);
  logic vld_q;
  logic lt_q;
  logic take;

  assign in_ready = ~vld_q | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      lt_q  <= 1'b0;
    end else if (take) begin
      vld_q <= 1'b1;
      lt_q  <= lt;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = {{(DATA_W-1){1'b0}}, lt_q};
endmodule

// File: rtl/slt_unit.sv
module slt_unit #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IMM_W     = 16,
  parameter int unsigned CMP_STYLE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [DATA_W-1:0] in_rs,
  input  logic [DATA_W-1:0] in_rt,
  input  logic [IMM_W-1:0]  in_imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result
);
  import slt_pkg::*;

  slt_op_e           op;
  logic [DATA_W-1:0] opb;
  logic              lt;

  assign op = slt_op_e'(in_op);

  slt_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .rt      (in_rt),
    .imm     (in_imm),
    .use_imm (op_uses_imm(op)),
    .opb     (opb)
  );

  slt_compare #(.DATA_W(DATA_W), .CMP_STYLE(CMP_STYLE)) u_cmp (
    .a           (in_rs),
    .b           (opb),
    .is_unsigned (op_is_unsigned(op)),
    .lt          (lt)
  );

  slt_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .lt         (lt),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result)
  );
endmodule

// File: rtl/slt_unit_checker.sv
module slt_unit_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_op,
  input logic [DATA_W-1:0] in_rs,
  input logic [DATA_W-1:0] in_rt,
  input logic [IMM_W-1:0]  in_imm,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result
);
  assert_result_form_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result[DATA_W-1:1] == '0));

  assert_equal_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_op[1] && (in_rs == in_rt)) |=> (out_result == '0));

  assert_accept_shows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  assert_flow_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  assert_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !in_valid) |=> !out_valid);
endmodule

bind slt_unit slt_unit_checker #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_rs      (in_rs),
  .in_rt      (in_rt),
  .in_imm     (in_imm),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result)
);

// File: tb/slt_unit_test.sv
`timescale 1ns/1ps
module slt_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic [31:0] in_rs = '0;
  logic [31:0] in_rt = '0;
  logic [15:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  bit    pend = 1'b0;
  logic [31:0] pend_exp;
  string pend_tag;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  slt_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rs(in_rs), .in_rt(in_rt), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
  );

  function automatic logic [31:0] expect_of(logic [1:0] op, logic [31:0] rs,
                                            logic [31:0] rt, logic [15:0] imm);
    logic signed [63:0] sa, sb;
    logic [63:0] ua, ub;
    logic [31:0] b;
    b  = op[1] ? (imm[15] ? 32'hFFFF_0000 + imm : {16'h0, imm}) : rt;
    ua = {32'h0, rs};
    ub = {32'h0, b};
    sa = rs[31] ? $signed(ua) - 64'sh1_0000_0000 : $signed(ua);
    sb = b[31]  ? $signed(ub) - 64'sh1_0000_0000 : $signed(ub);
    if (op[0]) return (ua < ub) ? 32'd1 : 32'd0;
    return (sa < sb) ? 32'd1 : 32'd0;
  endfunction

  function automatic logic [31:0] corner(int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h0000_0001;
      2: return 32'h0000_7FFF;  3: return 32'h0000_8000;
      4: return 32'h7FFF_FFFF;  5: return 32'h8000_0000;
      6: return 32'h8000_0001;  7: return 32'hFFFF_FFFF;
      8: return 32'hFFFF_FFFE;  9: return 32'hFFFF_8000;
      10: return 32'hFFFF_7FFF; default: return 32'h0001_0000;
    endcase
  endfunction

  function automatic logic [15:0] imm_corner(int i);
    case (i)
      0: return 16'h0000; 1: return 16'h0001; 2: return 16'h7FFF;
      3: return 16'h8000; 4: return 16'hFFFF; 5: return 16'hFFFE;
      6: return 16'h8001; default: return 16'h0010;
    endcase
  endfunction

  function automatic logic [31:0] next_rand(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [1:0] op);
    case (op)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check_pending();
    if (pend) begin
      chk("R8 out_valid", {31'h0, out_valid}, 32'd1);
      chk(pend_tag, out_result, pend_exp);
      chk("R10 in_ready", {31'h0, in_ready}, 32'd1);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [31:0] rs,
                      input logic [31:0] rt, input logic [15:0] imm, input string tag);
    @(negedge clk);
    check_pending();
    in_valid = 1'b1; in_op = op; in_rs = rs; in_rt = rt; in_imm = imm;
    pend = 1'b1;
    pend_exp = expect_of(op, rs, rt, imm);
    pend_tag = tag;
  endtask

  task automatic flush();
    @(negedge clk);
    check_pending();
    in_valid = 1'b0;
    pend = 1'b0;
    @(negedge clk);
    chk("R10 drain", {31'h0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid", {31'h0, out_valid}, 32'd0);
    chk("R1 in_ready", {31'h0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {31'h0, out_valid}, 32'd0);

    // named corner cases
    push(2'b00, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, "R2 signed min<max");
    push(2'b01, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, "R3 unsigned");
    push(2'b10, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, "R4 imm -1");
    push(2'b11, 32'h0001_0000, 32'h0, 16'h8000, "R5 imm 0x8000 high");
    push(2'b11, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, "R5 imm 0xFFFF top");
    push(2'b11, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, "R6 equal unsigned imm");
    push(2'b00, 32'h1234_5678, 32'h1234_5678, 16'h0, "R6 equal signed");
    push(2'b10, 32'h5, 32'h0, 16'h0006, "R7 imm ignores rt a");
    push(2'b10, 32'h5, 32'hFFFF_FFFF, 16'h0006, "R7 imm ignores rt b");
    push(2'b01, 32'h5, 32'h6, 16'h0000, "R7 reg ignores imm a");
    push(2'b01, 32'h5, 32'h6, 16'hFFFF, "R7 reg ignores imm b");

    // register forms over all corner pairs
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int k = 0; k < 2; k++)
          push(2'(k), corner(i), corner(j), corner(j + i) [15:0], tag_of(2'(k)));

    // immediate forms over corners, rt scrambled
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 2; k < 4; k++) begin
          seed = next_rand(seed);
          push(2'(k), corner(i), seed, imm_corner(j), tag_of(2'(k)));
        end

    // pseudo-random vectors
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a, b;
      seed = next_rand(seed); a = seed;
      seed = next_rand(seed); b = seed;
      push(2'(n % 4), a, b, b[31:16], tag_of(2'(n % 4)));
    end
    flush();

    // back-pressure episode
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 2'b01; in_rs = 32'd5; in_rt = 32'd9; in_imm = '0;
    @(negedge clk);
    chk("R8 stalled valid", {31'h0, out_valid}, 32'd1);
    chk("R8 first result", out_result, 32'd1);
    in_op = 2'b00; in_rs = 32'd9; in_rt = 32'd5;
    chk("R9 in_ready low", {31'h0, in_ready}, 32'd0);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk("R9 hold result", out_result, 32'd1);
      chk("R9 hold valid", {31'h0, out_valid}, 32'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 second beat", out_result, 32'd0);
    chk("R9 second valid", {31'h0, out_valid}, 32'd1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 drained", {31'h0, out_valid}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule